// File: doc/BRIEF.md
# Per-CPU Pending Interrupt Priority Selector

This block looks across a set of interrupt sources and, separately for each CPU, finds the most urgent source that is both enabled and pending for that CPU. Each source carries one 8-bit priority shared by all CPUs. Enable and pending are held per CPU, one bit per source. A smaller priority number is more urgent.

The winner's source index is shown as that CPU's highest-pending ID, but only when the winner's priority is below the CPU's priority mask. When nothing qualifies, the ID is the spurious value 1023. A per-CPU request line is raised when the published winner is also more urgent than the CPU's running priority. That priority is a 9-bit value, and 0x100 means the CPU is idle. A global enable and a per-CPU interface enable both gate the result. Both outputs are registered.

Top module: `pend_sel_top`

## Requirements
- R1: For each CPU, the highest-pending ID is the index of the enabled and pending source with the smallest priority value, provided the gating and the mask allow it.
- R2: When several qualifying sources share the smallest priority, the lowest source index wins.
- R3: When no source is both enabled and pending for a CPU, that CPU's ID is 1023 and its request line is low.
- R4: When the global enable is low, or a CPU's interface enable is low, that CPU's ID is 1023 and its request line is low.
- R5: A winner is published only when its priority is strictly less than the CPU's 8-bit mask. At equality or above, the ID is 1023 and the request is low.
- R6: The request line is high only when an ID is published and {1'b0, priority} is strictly less than the CPU's 9-bit running priority. The value 0x100 lets every priority through, and 0 blocks all.
- R7: Both outputs are registered. They reflect the inputs sampled at the previous rising clock edge. During reset the IDs are 1023 and the request lines are low.
- R8: Each CPU's result depends only on the global enable, that CPU's own enable, its own enable/pending bits, its own mask and its own running priority, plus the shared priorities.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| distEnable | input | 1 | Global enable |
| cpuEnable | input | NCPU | Per-CPU interface enable |
| srcEnable | input | NCPU*NSRC | Enable bits; bit c*NSRC+i is source i for CPU c |
| srcPending | input | NCPU*NSRC | Pending bits, same layout as srcEnable |
| srcPrio | input | NSRC*8 | Priority of source i in bits [8i+7:8i] |
| prioMask | input | NCPU*8 | Priority mask of CPU c in bits [8c+7:8c] |
| runPrio | input | NCPU*9 | Running priority of CPU c in bits [9c+8:9c] |
| bestId | output | NCPU*10 | Highest-pending ID of CPU c in bits [10c+9:10c]; 1023 when none |
| irqReq | output | NCPU | Request line per CPU |

## Verification
The assertions assume that the inputs are stable across each rising edge. They also assume that the values present in the cycle when reset is released are meaningful, because every check compares the registered outputs with the inputs of the previous edge. The bench changes every input only on the falling edge and keeps NSRC far below 1023, so a real source index can never collide with the spurious code. The sweeps use every enable/pending combination with several priority layouts, including all-equal priorities. They also place the mask and running-priority thresholds exactly at the winner's priority.

// File: rtl/pend_sel_pkg.sv
package pend_sel_pkg;
  localparam int PRIO_W = 8;
  localparam int RUN_W  = 9;
  localparam int ID_W   = 10;
  localparam logic [ID_W-1:0] SPURIOUS_ID = 10'd1023;

  typedef struct packed {
    logic publish;
    logic raise;
  } selStrobe_t;
endpackage

// File: rtl/pend_sel_ctrl.sv
module pend_sel_ctrl
  import pend_sel_pkg::*;
#(
  parameter int NCPU = 2
) (
  input  logic                     distEnable,
  input  logic [NCPU-1:0]          cpuEnable,
  input  logic [NCPU-1:0]          candValid,
  input  logic [NCPU*PRIO_W-1:0]   candPrio,
  input  logic [NCPU*PRIO_W-1:0]   prioMask,
  input  logic [NCPU*RUN_W-1:0]    runPrio,
  output selStrobe_t [NCPU-1:0]    strobes
);
  for (genvar c = 0; c < NCPU; c++) begin : g_cpu
    logic [PRIO_W-1:0] thisPrio;
    logic gateOpen;
    logic belowMask;
    logic belowRun;
    assign thisPrio  = candPrio[c*PRIO_W +: PRIO_W];
    assign gateOpen  = distEnable & cpuEnable[c];
    assign belowMask = thisPrio < prioMask[c*PRIO_W +: PRIO_W];
    assign belowRun  = {1'b0, thisPrio} < runPrio[c*RUN_W +: RUN_W];
    assign strobes[c].publish = gateOpen & candValid[c] & belowMask;
    assign strobes[c].raise   = gateOpen & candValid[c] & belowMask & belowRun;
  end
endmodule

// File: rtl/pend_sel_dp.sv
module pend_sel_dp
  import pend_sel_pkg::*;
#(
  parameter int NSRC = 4,
  parameter int NCPU = 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [NCPU*NSRC-1:0]     srcEnable,
  input  logic [NCPU*NSRC-1:0]     srcPending,
  input  logic [NSRC*PRIO_W-1:0]   srcPrio,
  input  selStrobe_t [NCPU-1:0]    strobes,
  output logic [NCPU-1:0]          candValid,
  output logic [NCPU*PRIO_W-1:0]   candPrio,
  output logic [NCPU*ID_W-1:0]     bestId,
  output logic [NCPU-1:0]          irqReq
);
  for (genvar c = 0; c < NCPU; c++) begin : g_cpu
    logic              scanValid;
    logic [PRIO_W-1:0] scanPrio;
    logic [ID_W-1:0]   scanIdx;

    // Ascending scan; replace only on strictly smaller value so ties keep the lower index.
    always_comb begin
      scanValid = 1'b0;
      scanPrio  = '1;
      scanIdx   = '0;
      for (int i = 0; i < NSRC; i++) begin
        if (srcEnable[c*NSRC+i] && srcPending[c*NSRC+i] &&
            (!scanValid || (srcPrio[i*PRIO_W +: PRIO_W] < scanPrio))) begin
          scanValid = 1'b1;
          scanPrio  = srcPrio[i*PRIO_W +: PRIO_W];
          scanIdx   = ID_W'(i);
        end
      end
    end

    assign candValid[c] = scanValid;
    assign candPrio[c*PRIO_W +: PRIO_W] = scanPrio;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        bestId[c*ID_W +: ID_W] <= SPURIOUS_ID;
        irqReq[c]              <= 1'b0;
      end else begin
        bestId[c*ID_W +: ID_W] <= strobes[c].publish ? scanIdx : SPURIOUS_ID;
        irqReq[c]              <= strobes[c].raise;
      end
    end

    // R7: the published ID is either spurious or a real source index
    a_r7_id_range: assert property (@(posedge clk) disable iff (!rstN)
      (bestId[c*ID_W +: ID_W] == SPURIOUS_ID) || (bestId[c*ID_W +: ID_W] < ID_W'(NSRC)));

    // R3: nothing pending for this CPU leaves it idle on the next edge
    a_r3_none_pending: assert property (@(posedge clk) disable iff (!rstN)
      (srcPending[c*NSRC +: NSRC] == '0) |=>
        (bestId[c*ID_W +: ID_W] == SPURIOUS_ID) && !irqReq[c]);
  end
endmodule

// File: rtl/pend_sel_top.sv
module pend_sel_top
  import pend_sel_pkg::*;
#(
  parameter int NSRC = 4,
  parameter int NCPU = 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     distEnable,
  input  logic [NCPU-1:0]          cpuEnable,
  input  logic [NCPU*NSRC-1:0]     srcEnable,
  input  logic [NCPU*NSRC-1:0]     srcPending,
  input  logic [NSRC*PRIO_W-1:0]   srcPrio,
  input  logic [NCPU*PRIO_W-1:0]   prioMask,
  input  logic [NCPU*RUN_W-1:0]    runPrio,
  output logic [NCPU*ID_W-1:0]     bestId,
  output logic [NCPU-1:0]          irqReq
);
  selStrobe_t [NCPU-1:0]   strobes;
  logic [NCPU-1:0]         candValid;
  logic [NCPU*PRIO_W-1:0]  candPrio;

  pend_sel_dp #(.NSRC(NSRC), .NCPU(NCPU)) u_dp (
    .clk(clk), .rstN(rstN),
    .srcEnable(srcEnable), .srcPending(srcPending), .srcPrio(srcPrio),
    .strobes(strobes), .candValid(candValid), .candPrio(candPrio),
    .bestId(bestId), .irqReq(irqReq)
  );

  pend_sel_ctrl #(.NCPU(NCPU)) u_ctrl (
    .distEnable(distEnable), .cpuEnable(cpuEnable),
    .candValid(candValid), .candPrio(candPrio),
    .prioMask(prioMask), .runPrio(runPrio), .strobes(strobes)
  );

  for (genvar c = 0; c < NCPU; c++) begin : g_chk
    // R4: a closed gate silences this CPU one edge later
    a_r4_gate_closed: assert property (@(posedge clk) disable iff (!rstN)
      (!distEnable || !cpuEnable[c]) |=>
        (bestId[c*ID_W +: ID_W] == SPURIOUS_ID) && !irqReq[c]);

    // R5: a zero mask lets nothing through
    a_r5_mask_zero: assert property (@(posedge clk) disable iff (!rstN)
      (prioMask[c*PRIO_W +: PRIO_W] == '0) |=> (bestId[c*ID_W +: ID_W] == SPURIOUS_ID));

    // R6: a zero running priority blocks the request line
    a_r6_run_zero: assert property (@(posedge clk) disable iff (!rstN)
      (runPrio[c*RUN_W +: RUN_W] == '0) |=> !irqReq[c]);

    // R6: a request always comes with a published ID
    a_r6_req_has_id: assert property (@(posedge clk) disable iff (!rstN)
      irqReq[c] |-> (bestId[c*ID_W +: ID_W] != SPURIOUS_ID));
  end
endmodule

// File: tb/tb_pend_sel_top.sv
`timescale 1ns/1ps
module tb_pend_sel_top;
  localparam int NSRC = 4;
  localparam int NCPU = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic distEnable;
  logic [NCPU-1:0] cpuEnable;
  logic [NCPU*NSRC-1:0] srcEnable, srcPending;
  logic [NSRC*8-1:0] srcPrio;
  logic [NCPU*8-1:0] prioMask;
  logic [NCPU*9-1:0] runPrio;
  logic [NCPU*10-1:0] bestId;
  logic [NCPU-1:0] irqReq;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  pend_sel_top #(.NSRC(NSRC), .NCPU(NCPU)) dut (
    .clk(clk), .rstN(rstN), .distEnable(distEnable), .cpuEnable(cpuEnable),
    .srcEnable(srcEnable), .srcPending(srcPending), .srcPrio(srcPrio),
    .prioMask(prioMask), .runPrio(runPrio), .bestId(bestId), .irqReq(irqReq)
  );

  task automatic check(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  // Independent reference computed from the requirements
  task automatic model(input int c, output int id, output int irq, output string tag);
    int best = -1;
    int bp = 256;
    for (int i = 0; i < NSRC; i++)
      if (srcEnable[c*NSRC+i] && srcPending[c*NSRC+i] && int'(srcPrio[i*8 +: 8]) < bp) begin
        bp = int'(srcPrio[i*8 +: 8]);
        best = i;
      end
    id = 1023;
    irq = 0;
    if (!distEnable || !cpuEnable[c]) tag = "R4";
    else if (best < 0) tag = "R3";
    else if (bp >= int'(prioMask[c*8 +: 8])) tag = "R5";
    else begin
      tag = "R1";
      id = best;
      irq = (bp < int'(runPrio[c*9 +: 9])) ? 1 : 0;
    end
  endtask

  task automatic stepAndCheck();
    @(posedge clk);
    @(negedge clk);
    for (int c = 0; c < NCPU; c++) begin
      int eid, eirq;
      string tg;
      model(c, eid, eirq, tg);
      check(tg, int'(bestId[c*10 +: 10]), eid);
      check("R6", int'(irqReq[c]), eirq);
    end
  endtask

  task automatic setPrioPattern(input int k);
    for (int i = 0; i < NSRC; i++) begin
      case (k)
        0: srcPrio[i*8 +: 8] = 8'h80;
        1: srcPrio[i*8 +: 8] = 8'(i * 8'h30);
        2: srcPrio[i*8 +: 8] = 8'(8'hF0 - i * 8'h40);
        default: srcPrio[i*8 +: 8] = (i < 2) ? 8'h10 : 8'h05;
      endcase
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    distEnable = 1'b1; cpuEnable = '1;
    srcEnable = '1; srcPending = '1;
    setPrioPattern(1);
    prioMask = {8'hFF, 8'hFF};
    runPrio = {9'h100, 9'h100};
    repeat (3) @(negedge clk);
    // R7 reset state
    for (int c = 0; c < NCPU; c++) begin
      check("R7", int'(bestId[c*10 +: 10]), 1023);
      check("R7", int'(irqReq[c]), 0);
    end
    rstN = 1'b1;
    stepAndCheck();

    // R7 latency: a change does not show before the next rising edge
    srcPending = '0;
    #1;
    check("R7", int'(bestId[9:0]), 0);
    check("R7", int'(irqReq[0]), 1);
    @(posedge clk); @(negedge clk);
    check("R7", int'(bestId[9:0]), 1023);

    // R2 tie: equal priorities, sources 2 and 3 qualify on CPU 0
    setPrioPattern(0);
    srcEnable = '1;
    srcPending = {4'b1111, 4'b1100};
    stepAndCheck();
    check("R2", int'(bestId[9:0]), 2);
    check("R2", int'(bestId[19:10]), 0);

    // R5 boundary: winner priority equals the mask, then one above it
    setPrioPattern(1);
    srcPending = {4'b0000, 4'b0010};
    prioMask = {8'hFF, 8'h30};
    stepAndCheck();
    check("R5", int'(bestId[9:0]), 1023);
    prioMask = {8'hFF, 8'h31};
    stepAndCheck();
    check("R5", int'(bestId[9:0]), 1);

    // R6 boundary with priority 0xFE
    srcPrio[0 +: 8] = 8'hFE;
    srcPending = {4'b0000, 4'b0001};
    prioMask = {8'hFF, 8'hFF};
    runPrio = {9'h100, 9'h0FE};
    stepAndCheck();
    check("R6", int'(irqReq[0]), 0);
    runPrio = {9'h100, 9'h0FF};
    stepAndCheck();
    check("R6", int'(irqReq[0]), 1);
    runPrio = {9'h100, 9'h100};
    stepAndCheck();
    check("R6", int'(irqReq[0]), 1);

    // R4 / R8: one CPU's interface enable does not touch the other
    srcPending = '1;
    cpuEnable = 2'b01;
    stepAndCheck();
    check("R8", int'(bestId[9:0]), 1);
    check("R4", int'(bestId[19:10]), 1023);
    distEnable = 1'b0;
    stepAndCheck();
    check("R4", int'(bestId[9:0]), 1023);
    distEnable = 1'b1;
    cpuEnable = '1;

    // Sweep: all enable/pending combos, priority layouts, masks
    for (int k = 0; k < 4; k++) begin
      setPrioPattern(k);
      for (int m = 0; m < 4; m++) begin
        case (m)
          0: prioMask[7:0] = 8'h00;
          1: prioMask[7:0] = 8'h10;
          2: prioMask[7:0] = 8'h80;
          default: prioMask[7:0] = 8'hFF;
        endcase
        prioMask[15:8] = 8'hFF;
        runPrio = {9'h060, 9'h100};
        for (int v = 0; v < 256; v++) begin
          srcEnable  = {~v[3:0], v[3:0]};
          srcPending = {v[7:4] ^ v[3:0], v[7:4]};
          stepAndCheck();
        end
      end
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule